// File: doc/BRIEF.md
# Byte-Wide SPI Port with Write-Collision Detection

This block connects a CPU register bus to a four-wire serial link and moves one byte per transfer, MSB first. It runs either as the clock-generating master or as a slave clocked from outside, and it supports both clock phases with the clock idling low. The CPU sees two registers: a data register (a write loads the byte to send, a read returns the last byte received) and a status register that carries a transfer-complete flag and a write-collision flag.

A CPU write to the data register that lands while the serial side is committed to a byte is a collision. The write is discarded, the byte on the wire goes out unchanged and the collision flag is set. No interrupt is raised. When a write counts as a collision depends on the role and the clock phase. In master mode and in slave mode with the second-edge phase, the window is the byte in flight. A slave using the first-edge phase must also refuse writes whenever its select input is low, because it cannot know when the first latching edge will come.

Both flags clear only through a two-access sequence: a status read that sees a flag set, then a data read. Received bytes sit in a buffer that the CPU reads in its own clock domain, so reads never collide.

Top module: `spi_wcol_port`

## Requirements
- R1: In master mode, a data write while idle drives ss_n_o low and produces 8 SCK pulses, each level lasting DIV system clocks, with SCK idle low. The byte is sent MSB first on mosi_o and the byte shifted in from miso_i becomes readable at the data address.
- R2: With cfg_cpha=0, outputs change on falling SCK and inputs are sampled on rising SCK, and the MSB is on the data line as soon as select goes low. With cfg_cpha=1, outputs change on rising SCK, inputs are sampled on falling SCK, and the data line is 0 until the first rising edge.
- R3: In master mode, a data write while a transfer is running is discarded. The transfer continues with ss_n_o low and sends the original byte, and the collision flag is set.
- R4: In slave mode with cfg_cpha=0, a data write while the slave select input is low is a collision: it is discarded and the collision flag is set. A write while select is high is accepted and is the byte sent.
- R5: In slave mode with cfg_cpha=1, a data write after select falls but before the first SCK edge is accepted. A write from the first SCK edge until the byte completes is a collision. miso_o stays 0 until the first SCK edge.
- R6: Status register at bus_addr=1: bit 7 is transfer-complete, bit 6 is write-collision, all other bits read 0. The data register is at bus_addr=0. The transfer-complete flag and the receive buffer update on the clock edge that samples the eighth bit: 15*DIV clocks after the starting write with cfg_cpha=0, and 16*DIV clocks with cfg_cpha=1.
- R7: A status read that sees either flag set, followed by a data read, clears both flags. A data write in place of that read leaves the collision flag set.
- R8: A data read that was not preceded by a flag-seeing status read returns the received byte and leaves the flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = master, 0 = slave (change only when idle) |
| cfg_cpha | input | 1 | Clock phase select (change only when idle) |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = status register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Contents of the register selected by bus_addr |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Serial data out in master mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode, 0 while deselected |
| miso_i | input | 1 | Serial data in for master mode |
| ss_n_o | output | 1 | Active-low select driven in master mode |
| ss_n_i | input | 1 | Active-low select received in slave mode |

## Verification
The bench stresses the phase-dependent collision windows. It writes during a running master transfer in both phases, during slave select before any edge in each phase, and midway through a slave byte. A design that lets a colliding write through shows up because the peer or the bench master receives the wrong byte. A design that uses the wrong window for a phase either flags a legal pre-edge write or misses the select-low case. The clearing sequence is probed with a data write between the status read and the data read, and with a data read that has no status read before it. A design that clears on any access or on a write would drop a flag early. The completion edge is pinned to the exact cycle in both phases, so an extra register stage is caught.

// File: rtl/spi_wcol_pkg.sv
package spi_wcol_pkg;

  typedef enum logic {
    REG_DATA = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;

  // A data write collides when the serial side is committed to a byte.
  function automatic logic coll_window(input logic master, input logic cpha,
                                       input logic sel_low, input logic active);
    if (master) return active;
    if (cpha)   return active;
    return sel_low | active;
  endfunction

  // Which serial edge samples the incoming bit.
  function automatic logic sample_edge(input logic cpha, input logic lead,
                                       input logic trail);
    return cpha ? trail : lead;
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_wcol_pkg::*;
#(
  parameter int DW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_master,
  input  logic          cfg_cpha,
  input  logic          ld,
  input  logic [DW-1:0] ld_data,
  input  logic          s_sck,
  input  logic          s_ss_n,
  input  logic          s_mosi,
  input  logic          miso_i,
  output logic          sck_o,
  output logic          ss_n_o,
  output logic          dout,
  output logic          active,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BW = $clog2(DW + 1);
  localparam int HW = $clog2(2 * DW + 1);

  logic [CW-1:0] divcnt;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] bitcnt;
  logic [DW-1:0] shreg;
  logic          mbusy, sck_q, sck_d, in_byte;

  logic tick, lead, trail, samp_e, shft_e, sin, last_bit, start, s_sel;

  assign tick     = cfg_master & mbusy & (divcnt == CW'(DIV - 1));
  assign s_sel    = ~cfg_master & ~s_ss_n;
  assign lead     = cfg_master ? (tick & ~sck_q) : (s_sel & s_sck & ~sck_d);
  assign trail    = cfg_master ? (tick & sck_q)  : (s_sel & ~s_sck & sck_d);
  assign samp_e   = sample_edge(cfg_cpha, lead, trail);
  assign shft_e   = cfg_cpha ? lead : trail;
  assign sin      = cfg_master ? miso_i : s_mosi;
  assign last_bit = (bitcnt == BW'(DW - 1));
  assign byte_done = samp_e & last_bit;
  assign rx_byte  = {shreg[DW-2:0], sin};
  assign active   = cfg_master ? mbusy : in_byte;
  assign start    = ld & cfg_master & ~mbusy;
  assign sck_o    = sck_q;
  assign ss_n_o   = ~mbusy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divcnt  <= '0;
      hcnt    <= '0;
      bitcnt  <= '0;
      shreg   <= '0;
      mbusy   <= 1'b0;
      sck_q   <= 1'b0;
      sck_d   <= 1'b0;
      in_byte <= 1'b0;
      dout    <= 1'b0;
    end else begin
      sck_d <= s_sck;
      // master clock divider
      if (tick)       divcnt <= '0;
      else if (mbusy) divcnt <= divcnt + 1'b1;
      if (start) begin
        mbusy  <= 1'b1;
        sck_q  <= 1'b0;
        hcnt   <= '0;
        divcnt <= '0;
      end else if (tick) begin
        sck_q <= ~sck_q;
        hcnt  <= hcnt + 1'b1;
        if (hcnt == HW'(2 * DW - 1)) mbusy <= 1'b0;
      end
      // bit engine
      if (!cfg_master && s_ss_n) begin
        bitcnt  <= '0;
        in_byte <= 1'b0;
        dout    <= cfg_cpha ? 1'b0 : shreg[DW-1];
      end else begin
        if (lead)      in_byte <= 1'b1;
        if (byte_done) in_byte <= 1'b0;
        if (samp_e) begin
          shreg  <= rx_byte;
          bitcnt <= last_bit ? '0 : bitcnt + 1'b1;
        end
        if (shft_e) dout <= shreg[DW-1];
      end
      // accepted CPU write
      if (ld) begin
        shreg <= ld_data;
        if (cfg_master) begin
          bitcnt <= '0;
          dout   <= cfg_cpha ? 1'b0 : ld_data[DW-1];
        end
      end
    end
  end
endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_rd,
  input  logic          dt_rd,
  input  logic          set_done,
  input  logic          set_wcol,
  input  logic [DW-1:0] rx_in,
  output logic          done_f,
  output logic          wcol_f,
  output logic [DW-1:0] rxbuf
);
  logic armed, clr;

  // A data read clears only after a status read saw a flag set.
  assign clr = dt_rd & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f <= 1'b0;
      wcol_f <= 1'b0;
      armed  <= 1'b0;
      rxbuf  <= '0;
    end else begin
      done_f <= set_done | (done_f & ~clr);
      wcol_f <= set_wcol | (wcol_f & ~clr);
      if (set_done) rxbuf <= rx_in;
      if (st_rd)      armed <= done_f | wcol_f;
      else if (dt_rd) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_wcol_port.sv
module spi_wcol_port
  import spi_wcol_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_master,
  input  logic          cfg_cpha,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck_o,
  input  logic          sck_i,
  output logic          mosi_o,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          miso_i,
  output logic          ss_n_o,
  input  logic          ss_n_i
);
  logic [2:0]    sync_q;
  logic          s_ss_n, s_sck, s_mosi;
  logic          wr_data, dt_rd, st_rd, coll_hit, load_ok;
  logic          dout, eng_active, byte_done, done_f, wcol_f;
  logic [DW-1:0] rx_byte, rxbuf, status;

  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n_i, sck_i, mosi_i}), .q(sync_q)
  );
  assign {s_ss_n, s_sck, s_mosi} = sync_q;

  assign wr_data  = bus_en &  bus_we & (bus_addr == REG_DATA);
  assign dt_rd    = bus_en & ~bus_we & (bus_addr == REG_DATA);
  assign st_rd    = bus_en & ~bus_we & (bus_addr == REG_STAT);
  assign coll_hit = wr_data & coll_window(cfg_master, cfg_cpha, ~s_ss_n, eng_active);
  assign load_ok  = wr_data & ~coll_hit;

  spi_shift_engine #(.DW(DW), .DIV(DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpha(cfg_cpha),
    .ld(load_ok), .ld_data(bus_wdata), .s_sck(s_sck), .s_ss_n(s_ss_n),
    .s_mosi(s_mosi), .miso_i(miso_i), .sck_o(sck_o), .ss_n_o(ss_n_o),
    .dout(dout), .active(eng_active), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  spi_status_flags #(.DW(DW)) u_flags (
    .clk(clk), .rst_n(rst_n), .st_rd(st_rd), .dt_rd(dt_rd),
    .set_done(byte_done), .set_wcol(coll_hit), .rx_in(rx_byte),
    .done_f(done_f), .wcol_f(wcol_f), .rxbuf(rxbuf)
  );

  assign status    = {done_f, wcol_f, {(DW-2){1'b0}}};
  assign bus_rdata = (bus_addr == REG_STAT) ? status : rxbuf;
  assign mosi_o    = cfg_master & dout;
  assign miso_o    = ~cfg_master & ~s_ss_n & dout;
endmodule

// File: rtl/spi_wcol_port_chk.sv
module spi_wcol_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_master,
  input logic cfg_cpha,
  input logic wr_data,
  input logic dt_rd,
  input logic coll_hit,
  input logic byte_done,
  input logic done_f,
  input logic wcol_f,
  input logic s_ss_n,
  input logic ss_n_o,
  input logic sck_o,
  input logic miso_o
);
  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && ss_n_o) |-> !sck_o);

  p_xfer_survives_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && coll_hit) |=> !ss_n_o);

  p_wcol_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    coll_hit |=> wcol_f);

  p_slave_sel_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && !cfg_cpha && wr_data && !s_ss_n) |=> wcol_f);

  p_miso_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_master && cfg_cpha && $fell(s_ss_n)) |-> !miso_o);

  p_done_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> $past(byte_done));

  p_write_keeps_wcol_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol_f && wr_data) |=> wcol_f);

  p_clear_by_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wcol_f) |-> $past(dt_rd));
endmodule

bind spi_wcol_port spi_wcol_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpha(cfg_cpha),
  .wr_data(wr_data), .dt_rd(dt_rd), .coll_hit(coll_hit), .byte_done(byte_done),
  .done_f(done_f), .wcol_f(wcol_f), .s_ss_n(s_ss_n), .ss_n_o(ss_n_o),
  .sck_o(sck_o), .miso_o(miso_o)
);

// File: tb/sim_spi_wcol_port.sv
`timescale 1ns/1ps
module sim_spi_wcol_port;
  localparam int DW  = 8;
  localparam int DIV = 4;
  localparam int H   = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_cpha = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic sck_o, sck_i = 1'b0, mosi_o, mosi_i = 1'b0;
  logic miso_o, miso_i = 1'b0, ss_n_o, ss_n_i = 1'b1;

  int errs = 0, checks = 0;
  logic [7:0] exp_q[$];
  logic [7:0] ptx = '0, psh = '0, prx = '0;

  always #2 clk = ~clk;

  spi_wcol_port #(.DW(DW), .DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpha(cfg_cpha),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sck_o(sck_o), .sck_i(sck_i), .mosi_o(mosi_o),
    .mosi_i(mosi_i), .miso_o(miso_o), .miso_i(miso_i), .ss_n_o(ss_n_o), .ss_n_i(ss_n_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  task automatic peek(output logic [7:0] s);
    bus_addr = 1; #1 s = bus_rdata;
  endtask

  // Behavioural peer for master mode; the monitor compares at select release.
  always @(negedge ss_n_o) if (cfg_master) begin
    psh = ptx; prx = '0;
    if (!cfg_cpha) miso_i = psh[7];
  end
  always @(posedge sck_o) if (cfg_master) begin
    if (!cfg_cpha) prx = {prx[6:0], mosi_o};
    else begin miso_i = psh[7]; psh = {psh[6:0], 1'b0}; end
  end
  always @(negedge sck_o) if (cfg_master) begin
    if (cfg_cpha) prx = {prx[6:0], mosi_o};
    else begin psh = {psh[6:0], 1'b0}; miso_i = psh[7]; end
  end
  always @(posedge ss_n_o) if (cfg_master && rst_n && exp_q.size() > 0) begin
    logic [7:0] e;
    e = exp_q.pop_front();
    chk(prx == e, "R1/R3 byte seen by peer", prx, e);
  end

  // Bench acting as master for slave-mode tests.
  task automatic sm_select(input logic [7:0] mtx);
    @(negedge clk); ss_n_i = 0;
    if (!cfg_cpha) mosi_i = mtx[7];
    repeat (H) @(negedge clk);
  endtask

  task automatic sm_clock(input logic [7:0] mtx, input bit mid_wr);
    logic [7:0] got, e, s;
    got = '0;
    for (int i = 0; i < 8; i++) begin
      if (mid_wr && i == 4) begin
        bus_wr(0, 8'h3C);
        peek(s); chk(s == 8'h40, "R5 mid-byte write collides", s, 8'h40);
      end
      if (!cfg_cpha) begin
        mosi_i = mtx[7-i];
        repeat (H) @(negedge clk);
        sck_i = 1; got = {got[6:0], miso_o};
        repeat (H) @(negedge clk);
        sck_i = 0;
      end else begin
        sck_i = 1; mosi_i = mtx[7-i];
        repeat (H) @(negedge clk);
        sck_i = 0; got = {got[6:0], miso_o};
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
    ss_n_i = 1;
    repeat (H) @(negedge clk);
    e = exp_q.pop_front();
    chk(got == e, "R4/R5 byte seen by bench master", got, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(s); chk(s == 8'h00, "R6 reset status", s, 8'h00);
    chk({7'b0, ss_n_o} == 8'h01, "R1 select idle high", {7'b0, ss_n_o}, 8'h01);
    chk({7'b0, sck_o} == 8'h00, "R1 clock idle low", {7'b0, sck_o}, 8'h00);

    // Master, first-edge phase, exact completion cycle
    cfg_master = 1; cfg_cpha = 0; ptx = 8'h5A; exp_q.push_back(8'hC3);
    bus_wr(0, 8'hC3);
    chk({6'b0, ss_n_o, mosi_o} == 8'h01, "R2 MSB valid as select falls", {6'b0, ss_n_o, mosi_o}, 8'h01);
    repeat (15*DIV - 1) @(negedge clk);
    peek(s); chk(s == 8'h00, "R6 done not early, phase 0", s, 8'h00);
    @(negedge clk);
    peek(s); chk(s == 8'h80, "R6 done on 8th sample, phase 0", s, 8'h80);
    wait (ss_n_o == 1'b1);
    bus_rd(1, s); chk(s == 8'h80, "R6 status layout", s, 8'h80);
    bus_rd(0, d); chk(d == 8'h5A, "R1 received byte", d, 8'h5A);
    @(negedge clk); peek(s); chk(s == 8'h00, "R7 flags cleared", s, 8'h00);

    // Master, second-edge phase
    cfg_cpha = 1; ptx = 8'h3C; exp_q.push_back(8'h96);
    bus_wr(0, 8'h96);
    chk({7'b0, mosi_o} == 8'h00, "R2 data line 0 before first edge", {7'b0, mosi_o}, 8'h00);
    repeat (16*DIV - 1) @(negedge clk);
    peek(s); chk(s == 8'h00, "R6 done not early, phase 1", s, 8'h00);
    @(negedge clk);
    peek(s); chk(s == 8'h80, "R6 done on 8th sample, phase 1", s, 8'h80);
    bus_rd(1, s);
    bus_rd(0, d); chk(d == 8'h3C, "R2 received byte, phase 1", d, 8'h3C);

    // Master collision, phase 0, and clearing sequence
    cfg_cpha = 0; ptx = 8'hE7; exp_q.push_back(8'h81);
    @(negedge clk);
    bus_wr(0, 8'h81);
    repeat (10) @(negedge clk);
    bus_wr(0, 8'h7E);
    peek(s); chk(s == 8'h40, "R3 collision flagged", s, 8'h40);
    chk({7'b0, ss_n_o} == 8'h00, "R3 transfer continues", {7'b0, ss_n_o}, 8'h00);
    bus_rd(1, s);
    bus_wr(0, 8'h11);
    peek(s); chk(s == 8'h40, "R7 data write does not clear", s, 8'h40);
    bus_rd(0, d);
    @(negedge clk); peek(s); chk(s == 8'h00, "R7 cleared before done", s, 8'h00);
    wait (ss_n_o == 1'b1);
    @(negedge clk); peek(s); chk(s == 8'h80, "R6 done after collided byte", s, 8'h80);
    bus_rd(0, d); chk(d == 8'hE7, "R8 data read returns byte", d, 8'hE7);
    @(negedge clk); peek(s); chk(s == 8'h80, "R8 unarmed read keeps flag", s, 8'h80);
    bus_rd(1, s); bus_rd(0, d);
    @(negedge clk); peek(s); chk(s == 8'h00, "R7 sequence clears done", s, 8'h00);

    // Master collision, phase 1
    cfg_cpha = 1; ptx = 8'h24; exp_q.push_back(8'h5B);
    @(negedge clk);
    bus_wr(0, 8'h5B);
    repeat (20) @(negedge clk);
    bus_wr(0, 8'hFF);
    peek(s); chk(s == 8'h40, "R3 collision flagged, phase 1", s, 8'h40);
    wait (ss_n_o == 1'b1);
    bus_rd(1, s); chk(s == 8'hC0, "R6 both flags", s, 8'hC0);
    bus_rd(0, d); chk(d == 8'h24, "R3 rx intact, phase 1", d, 8'h24);
    @(negedge clk); peek(s); chk(s == 8'h00, "R7 both cleared", s, 8'h00);

    // Slave, phase 0
    cfg_master = 0; cfg_cpha = 0;
    repeat (4) @(negedge clk);
    bus_wr(0, 8'hB4);
    peek(s); chk(s == 8'h00, "R4 write with select high accepted", s, 8'h00);
    exp_q.push_back(8'hB4);
    sm_select(8'h6D);
    bus_wr(0, 8'h0F);
    peek(s); chk(s == 8'h40, "R4 write with select low collides", s, 8'h40);
    sm_clock(8'h6D, 1'b0);
    peek(s); chk(s == 8'hC0, "R4 flags after slave byte", s, 8'hC0);
    bus_rd(1, s);
    bus_rd(0, d); chk(d == 8'h6D, "R6 slave received byte", d, 8'h6D);
    @(negedge clk); peek(s); chk(s == 8'h00, "R7 slave clear", s, 8'h00);

    // Slave, phase 1
    cfg_cpha = 1;
    repeat (4) @(negedge clk);
    sm_select(8'h92);
    bus_wr(0, 8'hA5);
    peek(s); chk(s == 8'h00, "R5 pre-edge write accepted", s, 8'h00);
    chk({7'b0, miso_o} == 8'h00, "R5 miso held before first edge", {7'b0, miso_o}, 8'h00);
    exp_q.push_back(8'hA5);
    sm_clock(8'h92, 1'b1);
    peek(s); chk(s == 8'hC0, "R5 flags after slave byte", s, 8'hC0);
    bus_rd(1, s);
    bus_rd(0, d); chk(d == 8'h92, "R5 slave received byte", d, 8'h92);
    @(negedge clk); peek(s); chk(s == 8'h00, "R7 final clear", s, 8'h00);

    repeat (10) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule